// File: doc/BRIEF.md
# Interrupt Request Pin Driver with Pulse or Level Signalling

This block turns enabled interrupt events into an active-low request pin for a host. Each event strobe bit is qualified by its own mask bit. A qualified event sets a sticky pending flag. The flags are grouped into a parameterised number of pending registers, and each register has a read strobe that clears its flags.

A mode input selects one of two ways to drive the pin:

- **Pulse mode.** Every qualified event produces a low pulse lasting a fixed number of clocks.
- **Level mode.** A qualified event pulls the pin low and holds it there until the host releases it. The host can release it in two ways:
  - a rising edge on the asynchronous acknowledge input, after that input has passed through a synchroniser; or
  - reading pending registers until no pending flag is left set.

Top module: `irq_req_out`

## Requirements
- R1: While reset is active and in the first cycle after it, `irq_n` is 1 and every pending flag is 0.
- R2: An event strobe bit whose enable bit is 1 sets pending flag bit i after the next clock edge. An event strobe bit whose enable bit is 0 changes neither the pending flags nor `irq_n`.
- R3: A read strobe on register r clears flag bits r*REG_W to r*REG_W+REG_W-1 at the next edge. A qualified event on one of those bits in the same cycle leaves that bit set.
- R4: In pulse mode (`level_mode` = 0), a qualified event drives `irq_n` low for exactly PULSE_CYCLES cycles, starting after the edge that samples the event. Another qualified event during the pulse restarts the full count.
- R5: In level mode (`level_mode` = 1), a qualified event drives `irq_n` low after the sampling edge. The pin stays low until one of the releases in R6 or R8 occurs.
- R6: In level mode, take `irq_ack` low at edge k-1 and high at edges k and k+1. Then `irq_n` is still low after edge k+1 and is 1 after edge k+2.
- R7: In pulse mode, `irq_ack` has no effect on `irq_n` or on the pending flags.
- R8: In level mode, a cycle with at least one read strobe that leaves every pending flag 0 returns `irq_n` to 1 after that edge. A read that leaves any flag set keeps `irq_n` low.
- R9: In level mode, a qualified event in the same cycle as a release keeps `irq_n` low. This holds for both an acknowledge edge and a final read. A flag set while the pin is already low stays set until its register is read.
- R10: Pending flag bit r*REG_W+b belongs to register r. It is cleared only by `reg_read[r]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | NUM_REGS*REG_W | One-cycle event strobes, one per flag |
| evt_enable | input | NUM_REGS*REG_W | Per-flag event mask, 1 = enabled |
| level_mode | input | 1 | 0 = pulse signalling, 1 = held level |
| irq_ack | input | 1 | Asynchronous acknowledge, rising edge releases level |
| reg_read | input | NUM_REGS | Read strobe per pending register, clears it |
| pend_flags | output | NUM_REGS*REG_W | Current pending flags |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two pairs of functions can fall in the same clock: a new qualified event with an acknowledge edge, and a new qualified event with the read that empties the last pending register.

- **Acknowledge collision.** The bench raises `irq_ack` for two clocks. It then drives an event into the cycle in which the synchronised edge takes effect.
- **Read collision.** The bench drives a read strobe and an event on the same register in one cycle.

In both cases the pin must stay low and the new flag must remain visible. A cycle-level behavioural model, compared on every clock, judges the result. Pulse retriggering is checked the same way, by sending a second event into the middle of a running pulse.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;

   typedef enum logic {
      IRQ_MODE_PULSE = 1'b0,
      IRQ_MODE_LEVEL = 1'b1
   } irq_mode_e;

   // Width of a down-counter that must hold the value n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/irq_ack_sync.sv
module irq_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_async,
   output logic ack_rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_ack_sync: STAGES must be at least 2");
   end

   // Synchroniser flops plus one history flop for edge detection.
   logic [STAGES:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], ack_async};
   end

   assign ack_rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
   parameter int NUM_REGS = 2,
   parameter int REG_W    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REGS*REG_W-1:0] set_bits,
   input  logic [NUM_REGS-1:0]       rd_strobe,
   output logic [NUM_REGS*REG_W-1:0] pend,
   output logic                      read_release
);

   localparam int NB = NUM_REGS * REG_W;

   logic [REG_W-1:0] pend_q [NUM_REGS];
   logic [REG_W-1:0] pend_d [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      // A new event outranks the read clear on the same bit.
      assign pend_d[r] = (pend_q[r] & {REG_W{~rd_strobe[r]}})
                       | set_bits[r*REG_W +: REG_W];

      always_ff @(posedge clk) begin
         if (!rst_n) pend_q[r] <= '0;
         else        pend_q[r] <= pend_d[r];
      end

      assign pend[r*REG_W +: REG_W] = pend_q[r];
   end

   logic any_left;
   always_comb begin
      any_left = 1'b0;
      for (int r = 0; r < NUM_REGS; r++) any_left = any_left | (|pend_d[r]);
   end

   assign read_release = (|rd_strobe) & ~any_left;

   if (NB < 1) begin : g_bad_bank
      $error("irq_pending_bank: bank must hold at least one flag");
   end

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
   parameter int PULSE_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic active
);

   if (PULSE_CYCLES < 1) begin : g_bad_len
      $error("irq_pulse_timer: PULSE_CYCLES must be at least 1");
   end

   if (PULSE_CYCLES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) active <= 1'b0;
         else        active <= fire;
      end
   end else begin : g_count
      localparam int CW = irq_out_pkg::cnt_width(PULSE_CYCLES);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n)          cnt <= '0;
         else if (fire)       cnt <= CW'(PULSE_CYCLES);
         else if (cnt != '0)  cnt <= cnt - CW'(1);
      end

      assign active = (cnt != '0);
   end

endmodule

// File: rtl/irq_level_hold.sv
module irq_level_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr_ack,
   input  logic clr_read,
   output logic held
);

   // Set has priority so an event landing on a release is never lost.
   always_ff @(posedge clk) begin
      if (!rst_n)                  held <= 1'b0;
      else if (set)                held <= 1'b1;
      else if (clr_ack | clr_read) held <= 1'b0;
   end

endmodule

// File: rtl/irq_req_out.sv
module irq_req_out
   import irq_out_pkg::*;
#(
   parameter int NUM_REGS     = 2,
   parameter int REG_W        = 4,
   parameter int PULSE_CYCLES = 3,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REGS*REG_W-1:0] evt_strobe,
   input  logic [NUM_REGS*REG_W-1:0] evt_enable,
   input  logic                      level_mode,
   input  logic                      irq_ack,
   input  logic [NUM_REGS-1:0]       reg_read,
   output logic [NUM_REGS*REG_W-1:0] pend_flags,
   output logic                      irq_n
);

   localparam int NB = NUM_REGS * REG_W;

   if (NUM_REGS < 1 || REG_W < 1) begin : g_bad_geom
      $error("irq_req_out: NUM_REGS and REG_W must be positive");
   end

   irq_mode_e       mode;
   logic [NB-1:0]   set_bits;
   logic            any_evt;
   logic            ack_rise;
   logic            read_release;
   logic            held;
   logic            pulse_on;

   assign mode     = irq_mode_e'(level_mode);
   assign set_bits = evt_strobe & evt_enable;
   assign any_evt  = |set_bits;

   irq_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_async (irq_ack),
      .ack_rise  (ack_rise)
   );

   irq_pending_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_bits     (set_bits),
      .rd_strobe    (reg_read),
      .pend         (pend_flags),
      .read_release (read_release)
   );

   irq_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (any_evt && mode == IRQ_MODE_PULSE),
      .active (pulse_on)
   );

   irq_level_hold u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (any_evt && mode == IRQ_MODE_LEVEL),
      .clr_ack  (ack_rise && mode == IRQ_MODE_LEVEL),
      .clr_read (read_release),
      .held     (held)
   );

   assign irq_n = ~(held | pulse_on);

endmodule

// File: rtl/irq_req_out_chk.sv
module irq_req_out_chk #(
   parameter int NUM_REGS = 2,
   parameter int REG_W    = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_REGS*REG_W-1:0] evt_strobe,
   input logic [NUM_REGS*REG_W-1:0] evt_enable,
   input logic                      level_mode,
   input logic [NUM_REGS-1:0]       reg_read,
   input logic [NUM_REGS*REG_W-1:0] pend_flags,
   input logic                      irq_n,
   input logic                      ack_rise,
   input logic                      held,
   input logic                      pulse_on
);

   localparam int NB = NUM_REGS * REG_W;

   logic [NB-1:0] rd_bits;
   logic [NB-1:0] qual;

   always_comb begin
      rd_bits = '0;
      for (int r = 0; r < NUM_REGS; r++)
         if (reg_read[r]) rd_bits[r*REG_W +: REG_W] = '1;
   end

   assign qual = evt_strobe & evt_enable;

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (irq_n && pend_flags == '0));

   assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (qual == '0 && reg_read == '0) |=> pend_flags == $past(pend_flags));

   assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_read != '0 && qual == '0) |=> (pend_flags & $past(rd_bits)) == '0);

   assert_pulse_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && qual != '0) |=> !irq_n);

   assert_level_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !(level_mode && ack_rise) && reg_read == '0) |=> !irq_n);

   assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (level_mode && ack_rise && qual == '0 && !pulse_on) |=> irq_n);

   assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (level_mode && reg_read != '0 && qual == '0 && (pend_flags & ~rd_bits) == '0
       && !pulse_on) |=> irq_n);

   assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (level_mode && qual != '0) |=> !irq_n);

endmodule

bind irq_req_out irq_req_out_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_strobe (evt_strobe),
   .evt_enable (evt_enable),
   .level_mode (level_mode),
   .reg_read   (reg_read),
   .pend_flags (pend_flags),
   .irq_n      (irq_n),
   .ack_rise   (ack_rise),
   .held       (held),
   .pulse_on   (pulse_on)
);

// File: tb/irq_req_out_bench.sv
module irq_req_out_bench;

   localparam int CLK_PERIOD   = 10;
   localparam int NUM_REGS     = 2;
   localparam int REG_W        = 4;
   localparam int PULSE_CYCLES = 3;
   localparam int NB           = NUM_REGS * REG_W;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NB-1:0]       evt_strobe = '0;
   logic [NB-1:0]       evt_enable = '0;
   logic                level_mode = 1'b0;
   logic                irq_ack = 1'b0;
   logic [NUM_REGS-1:0] reg_read = '0;
   logic [NB-1:0]       pend_flags;
   logic                irq_n;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_req_out #(
      .NUM_REGS(NUM_REGS), .REG_W(REG_W), .PULSE_CYCLES(PULSE_CYCLES), .SYNC_STAGES(2)
   ) u_irq_req_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_strobe (evt_strobe),
      .evt_enable (evt_enable),
      .level_mode (level_mode),
      .irq_ack    (irq_ack),
      .reg_read   (reg_read),
      .pend_flags (pend_flags),
      .irq_n      (irq_n)
   );

   // Behavioural reference model.
   logic [NB-1:0] m_pend = '0;
   bit            m_lvl = 1'b0;
   int            m_pc = 0;
   bit            ack_hist[$] = '{1'b0, 1'b0, 1'b0};

   always @(posedge clk) begin : model
      logic [NB-1:0] set_v, rdm, nxt;
      bit rise;
      if (!rst_n) begin
         m_pend = '0; m_lvl = 1'b0; m_pc = 0;
         ack_hist = '{1'b0, 1'b0, 1'b0};
      end else begin
         // ack seen two and three edges back gives the synchronised edge
         rise  = ack_hist[1] && !ack_hist[2];
         set_v = evt_strobe & evt_enable;
         rdm   = '0;
         for (int r = 0; r < NUM_REGS; r++)
            if (reg_read[r]) rdm[r*REG_W +: REG_W] = '1;
         nxt = (m_pend & ~rdm) | set_v;
         if (level_mode && set_v != '0) m_lvl = 1'b1;
         else if ((level_mode && rise) || (reg_read != '0 && nxt == '0)) m_lvl = 1'b0;
         if (!level_mode && set_v != '0) m_pc = PULSE_CYCLES;
         else if (m_pc > 0) m_pc = m_pc - 1;
         m_pend = nxt;
         ack_hist.push_front(irq_ack);
         void'(ack_hist.pop_back());
      end
   end

   // Clock-by-clock comparison against the model.
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (irq_n !== !(m_lvl || m_pc > 0)) begin
            errors++;
            $display("FAIL %s model compare irq_n: actual %0b expected %0b",
                     level_mode ? "R5" : "R4", irq_n, !(m_lvl || m_pc > 0));
         end
         checks++;
         if (pend_flags !== m_pend) begin
            errors++;
            $display("FAIL R2 model compare pend_flags: actual %0h expected %0h",
                     pend_flags, m_pend);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      tick(3);
      chk("R1 irq_n in reset", irq_n, 1);
      chk("R1 flags in reset", pend_flags, 0);
      rst_n = 1'b1;
      evt_enable = 8'h7F;
      tick();
      chk("R1 irq_n after reset", irq_n, 1);

      // Pulse mode, flag in register 1
      evt_strobe = 8'h20; tick(); evt_strobe = '0;
      chk("R10 flag position", pend_flags, 8'h20);
      chk("R4 pulse cycle 1", irq_n, 0);
      tick(); chk("R4 pulse cycle 2", irq_n, 0);
      tick(); chk("R4 pulse cycle 3", irq_n, 0);
      tick(); chk("R4 pulse ended", irq_n, 1);

      reg_read = 2'b01; tick(); reg_read = '0;
      chk("R10 other register read", pend_flags, 8'h20);
      reg_read = 2'b10; tick(); reg_read = '0;
      chk("R3 read clears register 1", pend_flags, 0);

      // Masked event
      evt_strobe = 8'h80; tick(); evt_strobe = '0;
      chk("R2 masked flag", pend_flags, 0);
      chk("R2 masked irq_n", irq_n, 1);

      // Retrigger
      evt_strobe = 8'h01; tick();
      evt_strobe = 8'h02; tick(); evt_strobe = '0;
      tick(2); chk("R4 retrigger still low", irq_n, 0);
      tick(); chk("R4 retrigger ended", irq_n, 1);

      // Acknowledge in pulse mode
      irq_ack = 1'b1; tick(2); irq_ack = 1'b0; tick(3);
      chk("R7 irq_n after ack", irq_n, 1);
      chk("R7 flags after ack", pend_flags, 8'h03);
      reg_read = 2'b01; tick(); reg_read = '0;

      // Level mode
      level_mode = 1'b1; tick();
      evt_strobe = 8'h10; tick(); evt_strobe = '0;
      chk("R5 level asserted", irq_n, 0);
      tick(8); chk("R5 level held", irq_n, 0);

      irq_ack = 1'b1; tick();
      chk("R6 low after edge k", irq_n, 0);
      tick(); irq_ack = 1'b0;
      chk("R6 low after edge k+1", irq_n, 0);
      tick(); chk("R6 released after edge k+2", irq_n, 1);
      chk("R9 flag kept after ack", pend_flags, 8'h10);

      // Read release
      evt_strobe = 8'h01; tick(); evt_strobe = '0;
      chk("R5 level asserted again", irq_n, 0);
      reg_read = 2'b01; tick(); reg_read = '0;
      chk("R8 partial read keeps low", irq_n, 0);
      reg_read = 2'b10; tick(); reg_read = '0;
      chk("R8 final read releases", irq_n, 1);
      chk("R8 flags empty", pend_flags, 0);

      // Event on the final read
      evt_strobe = 8'h04; tick(); evt_strobe = '0;
      reg_read = 2'b01; evt_strobe = 8'h08; tick();
      reg_read = '0; evt_strobe = '0;
      chk("R9 event on last read keeps low", irq_n, 0);
      chk("R3 set wins over read", pend_flags, 8'h08);
      reg_read = 2'b01; tick(); reg_read = '0;
      chk("R8 release after clearing", irq_n, 1);

      // Event on the acknowledge edge
      evt_strobe = 8'h40; tick(); evt_strobe = '0;
      irq_ack = 1'b1; tick(2);
      irq_ack = 1'b0; evt_strobe = 8'h20; tick(); evt_strobe = '0;
      chk("R9 event on ack edge keeps low", irq_n, 0);
      chk("R9 both flags pending", pend_flags, 8'h60);
      irq_ack = 1'b1; tick(2); irq_ack = 1'b0; tick();
      chk("R6 second ack releases", irq_n, 1);
      reg_read = 2'b11; tick(); reg_read = '0;
      chk("R3 all cleared", pend_flags, 0);

      tick(2);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog (R1 to R10 sequence): actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule